// File: doc/BRIEF.md
# Overlay Pixel Compositor with Indexed Palette

This block mixes a stream of overlay (on-screen graphics) pixels onto a stream of video pixels, one pixel per clock. Each overlay pixel arrives as a raw 32-bit storage word. The block cuts it to the configured storage width, decodes it into 8-bit red, green and blue plus a per-pixel alpha according to the configured colour format, and in 8-bit indexed form fetches the colour from a 256-entry palette. It then forms one effective alpha from the per-pixel alpha, a global alpha and a colour-key match, and blends the overlay colour over the video colour channel by channel.

The overlay appears only inside a rectangle given by an inclusive left/top corner and right/bottom corner, measured from (0,0) at the top-left. The pixel position comes in with each pixel. Outside the rectangle, or while the overlay is switched off, the video pixel leaves unchanged. Software programs formats, rectangle, key, global alpha and palette through a simple write port. The result leaves a fixed three cycles after the pixel enters.

Top module: `ovl_compositor`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_pix` is 0 until a pixel has gone through the pipeline.
- R2: A pixel taken with `pix_valid` high on a clock edge gives `out_valid` high after the third rising edge counted from that edge, and not earlier.
- R3: `out_pix` equals `vid_pix` when the overlay enable (control bit 8) is 0, or when the pixel lies outside the window. The window is inclusive: x from left to right and y from top to bottom. Address 1 holds left in bits 15:0 and top in bits 31:16. Address 2 holds right in bits 15:0 and bottom in bits 31:16.
- R4: A write to address 0 sets the control word. Bits 2:0 select the colour format: 000 indexed, 001 5-6-5, 010 1-5-5-5, 011 4-4-4-4, 100 8-8-8-8, and 101 to 111 act as 8-8-8-8. Bits 5:4 select the storage width. Bit 9 enables global alpha, bit 10 per-pixel alpha and bit 11 the colour key. Address 3 holds the 32-bit key and address 4 bits 7:0 hold the global alpha.
- R5: Storage code 01 (8 bits) keeps only word bits 7:0 and forces indexed format whatever bits 2:0 say. Code 10 (16 bits) keeps bits 15:0 and reads the rest as zero. Codes 11 and 00 (32 bits) keep the whole word, and an indexed pixel in 32-bit storage uses bits 7:0 with the other bytes as padding.
- R6: A write to address 5 latches a palette index from bits 7:0. A later write to address 6 stores its 32-bit data at that index. An entry holds alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0, and indexed pixels take their colour and per-pixel alpha from it.
- R7: In 5-6-5 format red is bits 15:11, green 10:5 and blue 4:0. Each field widens to 8 bits by repeating its top bits below it. The format has no per-pixel alpha, so it counts as 255.
- R8: In 1-5-5-5 format red, green and blue are bits 14:10, 9:5 and 4:0. In 4-4-4-4 format they are 11:8, 7:4 and 3:0, and a nibble n widens to {n,n}. In both formats, with per-pixel alpha enabled, bit 15 = 1 makes the pixel fully transparent and 0 makes it solid.
- R9: In 8-8-8-8 format the per-pixel alpha is bits 31:24 (0 transparent, 255 solid), and red, green and blue are bits 23:16, 15:8 and 7:0.
- R10: With the key enabled, a matching pixel is fully transparent. The match compares 16 bits (word 15:0 with key 15:0) in the three 16-bit formats, the index with key 7:0 in indexed format, and all 32 bits in 8-8-8-8.
- R11: A disabled alpha source counts as 255. The effective alpha is a = round(local × global / 255), or 0 on a key match. Each output channel is round((a × ovl + (255 − a) × vid) / 255). Pixels use red in bits 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (3) | Register address |
| reg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_x | input | COORD_W (16) | Pixel column |
| pix_y | input | COORD_W (16) | Pixel row |
| ovl_word | input | 32 | Raw overlay storage word |
| vid_pix | input | 24 | Video pixel, RGB 8-8-8 |
| out_valid | output | 1 | Blended pixel present |
| out_pix | output | 24 | Blended pixel, RGB 8-8-8 |

## Verification
The hardest case to reach from the ports is a colour-key match that must compare only part of the key. The bench loads a key whose upper half differs from the pixel and shows that a 16-bit format still treats the pixel as transparent, while a pixel one code away blends in. Forced indexing is reached by selecting 8-8-8-8 format with 8-bit storage and non-zero high bytes in the word. The bench expects a palette colour, so a decoder that trusted the format bits would show up. Window tests place pixels exactly on each edge and one step outside it.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   typedef enum logic [2:0] {
      FMT_IDX  = 3'd0,
      FMT_565  = 3'd1,
      FMT_555  = 3'd2,
      FMT_444  = 3'd3,
      FMT_8888 = 3'd4
   } fmt_e;

   typedef struct packed {
      logic [2:0] mode;
      logic [1:0] store;
      logic       ovl_en;
      logic       ga_en;
      logic       la_en;
      logic       key_en;
   } ctrl_t;

   localparam int unsigned CH_W    = 8;
   localparam int unsigned NUM_CH  = 3;
   localparam int unsigned PIX_W   = CH_W * NUM_CH;
   localparam int unsigned WORD_W  = 32;

   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_TL    = 1;
   localparam int unsigned A_BR    = 2;
   localparam int unsigned A_KEY   = 3;
   localparam int unsigned A_GA    = 4;
   localparam int unsigned A_PIDX  = 5;
   localparam int unsigned A_PDATA = 6;

   localparam logic [1:0] ST_8  = 2'b01;
   localparam logic [1:0] ST_16 = 2'b10;

   // rounded division of a product sum by 255
   function automatic logic [7:0] div255(input logic [16:0] num);
      logic [17:0] t;
      t = {1'b0, num} + 18'd127;
      return 8'(t / 18'd255);
   endfunction

endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
   import ovl_pkg::*;
#(
   parameter int unsigned REG_AW  = 3,
   parameter int unsigned COORD_W = 16,
   parameter int unsigned PAL_AW  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [REG_AW-1:0]   addr,
   input  logic [WORD_W-1:0]   wdata,
   output ctrl_t               ctrl,
   output logic [COORD_W-1:0]  win_l,
   output logic [COORD_W-1:0]  win_t,
   output logic [COORD_W-1:0]  win_r,
   output logic [COORD_W-1:0]  win_b,
   output logic [WORD_W-1:0]   key,
   output logic [CH_W-1:0]     galpha,
   input  logic [PAL_AW-1:0]   pal_rd_idx,
   output logic [WORD_W-1:0]   pal_rd_data
);
   localparam int unsigned PAL_DEPTH = 1 << PAL_AW;

   logic [PAL_AW-1:0] pal_idx;
   logic [WORD_W-1:0] pal_mem [PAL_DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl    <= '0;
         win_l   <= '0;
         win_t   <= '0;
         win_r   <= '0;
         win_b   <= '0;
         key     <= '0;
         galpha  <= '0;
         pal_idx <= '0;
      end else if (we) begin
         if (addr == REG_AW'(A_CTRL)) begin
            ctrl.mode   <= wdata[2:0];
            ctrl.store  <= wdata[5:4];
            ctrl.ovl_en <= wdata[8];
            ctrl.ga_en  <= wdata[9];
            ctrl.la_en  <= wdata[10];
            ctrl.key_en <= wdata[11];
         end
         if (addr == REG_AW'(A_TL)) begin
            win_l <= wdata[COORD_W-1:0];
            win_t <= wdata[16 +: COORD_W];
         end
         if (addr == REG_AW'(A_BR)) begin
            win_r <= wdata[COORD_W-1:0];
            win_b <= wdata[16 +: COORD_W];
         end
         if (addr == REG_AW'(A_KEY))  key     <= wdata;
         if (addr == REG_AW'(A_GA))   galpha  <= wdata[CH_W-1:0];
         if (addr == REG_AW'(A_PIDX)) pal_idx <= wdata[PAL_AW-1:0];
      end
   end

   // palette storage: written through the latched index, read one cycle later
   always_ff @(posedge clk) begin
      if (we && addr == REG_AW'(A_PDATA))
         pal_mem[pal_idx] <= wdata;
      pal_rd_data <= pal_mem[pal_rd_idx];
   end

endmodule

// File: rtl/ovl_unpack.sv
module ovl_unpack
   import ovl_pkg::*;
(
   input  logic [2:0]        mode,
   input  logic [1:0]        store,
   input  logic              la_en,
   input  logic              key_en,
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] pal_entry,
   input  logic [WORD_W-1:0] key,
   output logic [PIX_W-1:0]  rgb,
   output logic [CH_W-1:0]   la,
   output logic              key_hit
);
   logic [WORD_W-1:0] w;
   fmt_e              fmt;
   logic [CH_W-1:0]   la_raw;
   logic              match;

   always_comb begin
      unique case (store)
         ST_8:    w = {24'd0, word[7:0]};
         ST_16:   w = {16'd0, word[15:0]};
         default: w = word;
      endcase
   end

   always_comb begin
      if (store == ST_8)       fmt = FMT_IDX;
      else if (mode > 3'd4)    fmt = FMT_8888;
      else                     fmt = fmt_e'(mode);
   end

   always_comb begin
      unique case (fmt)
         FMT_IDX: begin
            rgb    = pal_entry[23:0];
            la_raw = pal_entry[31:24];
            match  = (w[7:0] == key[7:0]);
         end
         FMT_565: begin
            rgb    = {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2]};
            la_raw = 8'hFF;
            match  = (w[15:0] == key[15:0]);
         end
         FMT_555: begin
            rgb    = {w[14:10], w[14:12], w[9:5], w[9:7], w[4:0], w[4:2]};
            la_raw = w[15] ? 8'h00 : 8'hFF;
            match  = (w[15:0] == key[15:0]);
         end
         FMT_444: begin
            rgb    = {w[11:8], w[11:8], w[7:4], w[7:4], w[3:0], w[3:0]};
            la_raw = w[15] ? 8'h00 : 8'hFF;
            match  = (w[15:0] == key[15:0]);
         end
         default: begin
            rgb    = w[23:0];
            la_raw = w[31:24];
            match  = (w == key);
         end
      endcase
   end

   assign la      = la_en ? la_raw : 8'hFF;
   assign key_hit = key_en & match;

endmodule

// File: rtl/ovl_mix.sv
module ovl_mix
   import ovl_pkg::*;
(
   input  logic [CH_W-1:0]  alpha,
   input  logic [PIX_W-1:0] ovl,
   input  logic [PIX_W-1:0] vid,
   output logic [PIX_W-1:0] mix
);
   logic [CH_W-1:0] inv;
   assign inv = 8'hFF - alpha;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [16:0] num;
      assign num = 17'(alpha) * 17'(ovl[c*CH_W +: CH_W])
                 + 17'(inv)   * 17'(vid[c*CH_W +: CH_W]);
      assign mix[c*CH_W +: CH_W] = div255(num);
   end

endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
   import ovl_pkg::*;
#(
   parameter int unsigned REG_AW  = 3,
   parameter int unsigned COORD_W = 16,
   parameter int unsigned PAL_AW  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   input  logic               pix_valid,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [31:0]        ovl_word,
   input  logic [23:0]        vid_pix,
   output logic               out_valid,
   output logic [23:0]        out_pix
);
   if (REG_AW < 3) begin : g_bad_aw
      $error("REG_AW must cover seven register addresses");
   end
   if (COORD_W < 1 || COORD_W > 16) begin : g_bad_coord
      $error("COORD_W must lie in 1..16");
   end
   if (PAL_AW < 1 || PAL_AW > 8) begin : g_bad_pal
      $error("PAL_AW must lie in 1..8");
   end

   ctrl_t               ctrl;
   logic [COORD_W-1:0]  win_l, win_t, win_r, win_b;
   logic [WORD_W-1:0]   key;
   logic [CH_W-1:0]     galpha;
   logic [WORD_W-1:0]   pal_q;

   ovl_cfg_regs #(.REG_AW(REG_AW), .COORD_W(COORD_W), .PAL_AW(PAL_AW)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (reg_we),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .ctrl        (ctrl),
      .win_l       (win_l),
      .win_t       (win_t),
      .win_r       (win_r),
      .win_b       (win_b),
      .key         (key),
      .galpha      (galpha),
      .pal_rd_idx  (ovl_word[PAL_AW-1:0]),
      .pal_rd_data (pal_q)
   );

   // stage 1: capture, window test, palette fetch
   logic              in_win;
   logic              s1_valid, s1_hit;
   logic [WORD_W-1:0] s1_word;
   logic [PIX_W-1:0]  s1_vid;

   assign in_win = (pix_x >= win_l) && (pix_x <= win_r) &&
                   (pix_y >= win_t) && (pix_y <= win_b);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= 1'b0;
         s1_word  <= '0;
         s1_vid   <= '0;
      end else begin
         s1_valid <= pix_valid;
         s1_hit   <= ctrl.ovl_en & in_win;
         s1_word  <= ovl_word;
         s1_vid   <= vid_pix;
      end
   end

   // decode and alpha combine between stage 1 and stage 2
   logic [PIX_W-1:0] rgb1;
   logic [CH_W-1:0]  la1, ga_eff, a1;
   logic             key_hit1;
   logic [15:0]      prod;

   ovl_unpack u_unpack (
      .mode      (ctrl.mode),
      .store     (ctrl.store),
      .la_en     (ctrl.la_en),
      .key_en    (ctrl.key_en),
      .word      (s1_word),
      .pal_entry (pal_q),
      .key       (key),
      .rgb       (rgb1),
      .la        (la1),
      .key_hit   (key_hit1)
   );

   assign ga_eff = ctrl.ga_en ? galpha : 8'hFF;
   assign prod   = 16'(la1) * 16'(ga_eff);
   assign a1     = key_hit1 ? 8'h00 : div255({1'b0, prod});

   // stage 2
   logic             s2_valid, s2_hit;
   logic [CH_W-1:0]  s2_a;
   logic [PIX_W-1:0] s2_ovl, s2_vid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_hit   <= 1'b0;
         s2_a     <= '0;
         s2_ovl   <= '0;
         s2_vid   <= '0;
      end else begin
         s2_valid <= s1_valid;
         s2_hit   <= s1_hit;
         s2_a     <= a1;
         s2_ovl   <= rgb1;
         s2_vid   <= s1_vid;
      end
   end

   logic [PIX_W-1:0] mix2;

   ovl_mix u_mix (
      .alpha (s2_a),
      .ovl   (s2_ovl),
      .vid   (s2_vid),
      .mix   (mix2)
   );

   // stage 3: output
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= s2_valid;
         out_pix   <= s2_hit ? mix2 : s2_vid;
      end
   end

endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pix_valid,
   input logic        out_valid,
   input logic [23:0] out_pix,
   input logic        s1_valid,
   input logic        s1_key_hit,
   input logic        s2_valid,
   input logic        s2_hit,
   input logic [7:0]  s2_a,
   input logic [23:0] s2_ovl,
   input logic [23:0] s2_vid
);
   logic [1:0] warm;

   always_ff @(posedge clk) begin
      if (!rst_n)           warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> (out_valid == $past(pix_valid, 3)));

   assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && !s2_hit) |=> (out_pix == $past(s2_vid)));

   assert_key_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_key_hit) |=> (s2_a == 8'h00));

   assert_alpha_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_a == 8'h00) |=> (out_pix == $past(s2_vid)));

   assert_alpha_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && s2_hit && s2_a == 8'hFF) |=> (out_pix == $past(s2_ovl)));

endmodule

bind ovl_compositor ovl_compositor_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_valid  (pix_valid),
   .out_valid  (out_valid),
   .out_pix    (out_pix),
   .s1_valid   (s1_valid),
   .s1_key_hit (key_hit1),
   .s2_valid   (s2_valid),
   .s2_hit     (s2_hit),
   .s2_a       (s2_a),
   .s2_ovl     (s2_ovl),
   .s2_vid     (s2_vid)
);

// File: tb/ovl_compositor_bench.sv
`timescale 1ns/1ps
module ovl_compositor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        pix_valid = 1'b0;
   logic [15:0] pix_x = '0, pix_y = '0;
   logic [31:0] ovl_word = '0;
   logic [23:0] vid_pix = '0;
   logic        out_valid;
   logic [23:0] out_pix;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   ovl_compositor u_ovl_compositor (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .pix_valid(pix_valid), .pix_x(pix_x),
      .pix_y(pix_y), .ovl_word(ovl_word), .vid_pix(vid_pix),
      .out_valid(out_valid), .out_pix(out_pix)
   );

   // ---------- reference arithmetic from the requirements ----------
   function automatic int rdiv(input int n);
      return (n + 127) / 255;
   endfunction

   function automatic logic [23:0] blend(input int a, input logic [23:0] o,
                                         input logic [23:0] v);
      logic [23:0] r;
      for (int c = 0; c < 3; c++)
         r[c*8 +: 8] = 8'(rdiv(a * o[c*8 +: 8] + (255 - a) * v[c*8 +: 8]));
      return r;
   endfunction

   function automatic logic [31:0] ctl(input logic [2:0] mode, input logic [1:0] st,
                                       input bit en, input bit ga, input bit la, input bit ky);
      return {20'd0, ky, la, ga, en, 2'b00, st, 1'b0, mode};
   endfunction

   // ---------- drivers ----------
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // sends one pixel and checks timing (R2) and value
   task automatic pix(input string req, input int x, input int y,
                      input logic [31:0] w, input logic [23:0] v, input logic [23:0] exp);
      logic early;
      @(negedge clk);
      pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); ovl_word = w; vid_pix = v;
      @(negedge clk);
      pix_valid = 1'b0;
      @(negedge clk);
      early = out_valid;
      @(negedge clk);
      check("R2 early", {31'd0, early}, 32'd0);
      check("R2 valid", {31'd0, out_valid}, 32'd1);
      check(req, {8'd0, out_pix}, {8'd0, exp});
   endtask

   task automatic full_window();
      wr(3'd1, 32'h0000_0000);
      wr(3'd2, 32'hFFFF_FFFF);
   endtask

   // ---------- scenarios ----------
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
      check("R1 pix in reset", {8'd0, out_pix}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 valid after", {31'd0, out_valid}, 32'd0);
      check("R1 pix after", {8'd0, out_pix}, 32'd0);
   endtask

   task automatic t_window();
      wr(3'd0, ctl(3'd1, 2'b10, 1, 0, 0, 0));
      wr(3'd1, {16'd20, 16'd10});
      wr(3'd2, {16'd40, 16'd30});
      pix("R3 top-left edge",     10, 20, 32'hF800, 24'h123456, 24'hFF0000);
      pix("R3 bottom-right edge", 30, 40, 32'hF800, 24'h123456, 24'hFF0000);
      pix("R3 left of window",     9, 20, 32'hF800, 24'h123456, 24'h123456);
      pix("R3 right of window",   31, 40, 32'hF800, 24'h123456, 24'h123456);
      pix("R3 below window",      10, 41, 32'hF800, 24'h123456, 24'h123456);
      pix("R3 above window",      15, 19, 32'hF800, 24'h123456, 24'h123456);
      wr(3'd0, ctl(3'd1, 2'b10, 0, 0, 0, 0));
      pix("R3 overlay off",       15, 25, 32'hF800, 24'h654321, 24'h654321);
   endtask

   task automatic t_565();
      full_window();
      wr(3'd0, ctl(3'd1, 2'b10, 1, 0, 1, 0));
      pix("R7 green full", 5, 5, 32'h07E0, 24'h111111, 24'h00FF00);
      pix("R7 replication", 5, 5, 32'h8410, 24'h111111, 24'h848284);
      wr(3'd4, 32'd128);
      wr(3'd0, ctl(3'd1, 2'b10, 1, 1, 1, 0));
      pix("R7 565 with global", 5, 5, 32'hF800, 24'h204060,
          blend(rdiv(255 * 128), 24'hFF0000, 24'h204060));
   endtask

   task automatic t_555_444();
      full_window();
      wr(3'd0, ctl(3'd2, 2'b10, 1, 0, 1, 0));
      pix("R8 555 solid",       1, 1, 32'h7C00, 24'h0A0B0C, 24'hFF0000);
      pix("R8 555 transparent", 1, 1, 32'hFC00, 24'h0A0B0C, 24'h0A0B0C);
      pix("R8 555 blue",        1, 1, 32'h0011, 24'h0A0B0C, 24'h00008C);
      wr(3'd0, ctl(3'd2, 2'b10, 1, 0, 0, 0));
      pix("R8 555 switch off",  1, 1, 32'hFC00, 24'h0A0B0C, 24'hFF0000);
      wr(3'd0, ctl(3'd3, 2'b10, 1, 0, 1, 0));
      pix("R8 444 red",         1, 1, 32'h0F00, 24'h0A0B0C, 24'hFF0000);
      pix("R8 444 mixed",       1, 1, 32'h05A3, 24'h0A0B0C, 24'h55AA33);
      pix("R8 444 transparent", 1, 1, 32'h8F00, 24'h0A0B0C, 24'h0A0B0C);
   endtask

   task automatic t_8888();
      full_window();
      wr(3'd4, 32'd200);
      wr(3'd0, ctl(3'd4, 2'b11, 1, 1, 1, 0));
      pix("R9 R11 local x global", 2, 2, 32'h8011_2233, 24'hC0C0C0,
          blend(rdiv(128 * 200), 24'h112233, 24'hC0C0C0));
      pix("R9 local alpha zero", 2, 2, 32'h0011_2233, 24'hC0C0C0, 24'hC0C0C0);
      wr(3'd0, ctl(3'd4, 2'b11, 1, 1, 0, 0));
      pix("R11 local disabled", 2, 2, 32'h0011_2233, 24'hC0C0C0,
          blend(200, 24'h112233, 24'hC0C0C0));
      wr(3'd0, ctl(3'd7, 2'b11, 1, 0, 1, 0));
      pix("R4 code 111 as 8888", 2, 2, 32'hFF44_5566, 24'h000000, 24'h445566);
   endtask

   task automatic t_palette();
      full_window();
      wr(3'd5, 32'd7);
      wr(3'd6, 32'hFF10_2030);
      wr(3'd5, 32'd8);
      wr(3'd6, 32'hFF40_5060);
      wr(3'd0, ctl(3'd0, 2'b01, 1, 0, 1, 0));
      pix("R6 entry 7", 3, 3, 32'h07, 24'h000000, 24'h102030);
      pix("R6 entry 8", 3, 3, 32'h08, 24'h000000, 24'h405060);
      wr(3'd5, 32'd7);
      wr(3'd6, 32'h80A0_B0C0);
      pix("R6 entry 7 rewritten", 3, 3, 32'h07, 24'h202020,
          blend(128, 24'hA0B0C0, 24'h202020));
      pix("R6 entry 8 kept", 3, 3, 32'h08, 24'h000000, 24'h405060);
   endtask

   task automatic t_storage();
      full_window();
      wr(3'd5, 32'd5);
      wr(3'd6, 32'hFFAA_BBCC);
      wr(3'd0, ctl(3'd4, 2'b01, 1, 0, 1, 0));
      pix("R5 8-bit forces indexed", 4, 4, 32'hFFFF_FF05, 24'h010203, 24'hAABBCC);
      wr(3'd0, ctl(3'd0, 2'b11, 1, 0, 1, 0));
      pix("R5 indexed padding", 4, 4, 32'hDEAD_BE05, 24'h010203, 24'hAABBCC);
      wr(3'd0, ctl(3'd4, 2'b10, 1, 0, 1, 0));
      pix("R5 16-bit drops top", 4, 4, 32'hFF00_1234, 24'h010203, 24'h010203);
      wr(3'd0, ctl(3'd1, 2'b11, 1, 0, 0, 0));
      pix("R5 565 in 32-bit", 4, 4, 32'hABCD_F800, 24'h010203, 24'hFF0000);
   endtask

   task automatic t_key();
      full_window();
      wr(3'd3, 32'hABCD_F800);
      wr(3'd0, ctl(3'd1, 2'b10, 1, 0, 0, 1));
      pix("R10 16-bit key match", 6, 6, 32'hF800, 24'h336699, 24'h336699);
      pix("R10 16-bit near miss", 6, 6, 32'hF801, 24'h336699, 24'hFF0008);
      wr(3'd0, ctl(3'd1, 2'b10, 1, 0, 0, 0));
      pix("R10 key disabled", 6, 6, 32'hF800, 24'h336699, 24'hFF0000);
      wr(3'd5, 32'd7);
      wr(3'd6, 32'hFF01_0101);
      wr(3'd3, 32'hFFFF_FF07);
      wr(3'd0, ctl(3'd0, 2'b01, 1, 0, 0, 1));
      pix("R10 index key", 6, 6, 32'h07, 24'h336699, 24'h336699);
      wr(3'd3, 32'h8011_2233);
      wr(3'd0, ctl(3'd4, 2'b11, 1, 0, 0, 1));
      pix("R10 32-bit match", 6, 6, 32'h8011_2233, 24'h336699, 24'h336699);
      pix("R10 32-bit alpha differs", 6, 6, 32'h8111_2233, 24'h336699, 24'h112233);
   endtask

   task automatic t_global();
      full_window();
      wr(3'd4, 32'd0);
      wr(3'd0, ctl(3'd4, 2'b11, 1, 0, 0, 0));
      pix("R4 R11 global disabled", 7, 7, 32'h0077_8899, 24'h102030, 24'h778899);
      wr(3'd0, ctl(3'd4, 2'b11, 1, 1, 0, 0));
      pix("R11 global zero", 7, 7, 32'h0077_8899, 24'h102030, 24'h102030);
      wr(3'd4, 32'h0000_FF40);
      pix("R4 global uses low byte", 7, 7, 32'h0077_8899, 24'h102030,
          blend(64, 24'h778899, 24'h102030));
   endtask

   initial begin
      t_reset();
      t_window();
      t_565();
      t_555_444();
      t_8888();
      t_palette();
      t_storage();
      t_key();
      t_global();
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog got=expired exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule